// File: doc/BRIEF.md
# Compact-instruction expander

This block is a purely combinational expander for one group of 16-bit compact instructions: byte and halfword loads and stores, the byte and halfword zero- and sign-extension operations, bitwise invert, and a register-to-register multiply. Each compact word is turned into the 32-bit instruction that has the same effect, so the execution pipeline only ever sees full-length instructions. The encodings follow the 32-bit base integer set with the multiply and bit-manipulation additions, for 32-bit data only.

Two enable inputs state whether the multiply extension (full or multiply-only) and the bit-manipulation extension are present. A compact form whose full-length target belongs to a missing extension is reported as illegal instead of being expanded. Any 16-bit word outside this group produces neither flag, so a neighbouring expander can claim it. Register access, address arithmetic and execution belong to other blocks.

Top module: `cmp16_expand`

## Requirements
- R1: With bits[1:0]=00 and bits[15:10]=100000, the output is a zero-extending byte load (funct3 100, opcode 0000011) with rs1 from bits[9:7], rd from bits[4:2], and a 12-bit immediate whose bit 0 is input bit 6, whose bit 1 is input bit 5, and whose upper bits are zero.
- R2: With bits[1:0]=00 and bits[15:10]=100001, the output is a halfword load, sign-extending (funct3 001) when bit 6 is 1 and zero-extending (funct3 101) when bit 6 is 0; the immediate is 2 when bit 5 is 1 and 0 otherwise; registers as in R1.
- R3: With bits[1:0]=00, bits[15:10]=100010 gives a byte store (funct3 000, opcode 0100011) with the R1 offset, and bits[15:10]=100011 with bit 6=0 gives a halfword store (funct3 001) with offset 0 or 2 from bit 5; the base register is bits[9:7] and the data register is bits[4:2]. The halfword store pattern with bit 6=1 is reserved and reported illegal.
- R4: With bits[1:0]=01, bits[15:10]=100111 and bits[6:5]=10, the output is a multiply (funct7 0000001, funct3 000, opcode 0110011) with rd and rs1 from bits[9:7] and rs2 from bits[4:2]; when the multiply enable is 0 the word is illegal.
- R5: In the unary group (bits[1:0]=01, bits[15:10]=100111, bits[6:5]=11), selector bits[4:2]=001 gives sign-extend byte (imm 0x604, funct3 001, opcode 0010011), 010 gives zero-extend halfword (funct7 0000100, rs2 0, funct3 100, opcode 0110011) and 011 gives sign-extend halfword (imm 0x605, funct3 001, opcode 0010011), with rd=rs1 from bits[9:7]; these three are illegal when the bit-manipulation enable is 0.
- R6: In the unary group, selector 000 gives an AND-immediate with 0xFF (funct3 111) and selector 101 gives an XOR-immediate with 0xFFF (funct3 100), both opcode 0010011 with rd=rs1 from bits[9:7], independent of both enables.
- R7: Unary selectors 100, 110 and 111 are reserved and reported illegal whatever the enables.
- R8: Every 3-bit register field f names register 8+f, so the 5-bit index is {01, f}.
- R9: A word matching none of the patterns above drives valid, illegal and the 32-bit output all to zero.
- R10: Valid and illegal are never both 1, and whenever valid is 0 the 32-bit output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 16 | Compact instruction word |
| mul_en_i | input | 1 | Multiply extension (full or multiply-only) present |
| bitmanip_en_i | input | 1 | Bit-manipulation extension present |
| instr_o | output | 32 | Expanded instruction, zero when not valid |
| valid_o | output | 1 | Word belongs to the group and expands legally |
| illegal_o | output | 1 | Word belongs to the group but is reserved or its target is disabled |

## Verification
The assertions watch, on every input change, that the two flags are exclusive, that the output is zero unless valid, that every expanded register lies in the x8..x15 window, and that no multiply or bit-manipulation encoding is ever produced while its enable is low. What they cannot show is that each compact word maps to the right full-length encoding: the exact immediate placement, including the swapped byte-offset bits, the funct3 choice between signed and unsigned halfword loads, and the per-selector unary mapping are shown only by the bench, which sweeps every register pair and offset against independently built encodings and repeats the gated forms with each enable cleared.

// File: rtl/cmp16_expand.sv
module cmp16_expand (
  input  logic [15:0] instr_i,
  input  logic        mul_en_i,
  input  logic        bitmanip_en_i,
  output logic [31:0] instr_o,
  output logic        valid_o,
  output logic        illegal_o
);
  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;
  localparam logic [6:0] OPC_OPIMM = 7'b0010011;
  localparam logic [6:0] OPC_OP    = 7'b0110011;

  logic [4:0]  reg_hi, reg_lo;
  logic [5:0]  major;
  logic [11:0] off_byte, off_half;
  logic [31:0] cand;
  logic        hit, bad;

  assign reg_hi   = {2'b01, instr_i[9:7]};
  assign reg_lo   = {2'b01, instr_i[4:2]};
  assign major    = instr_i[15:10];
  assign off_byte = {10'd0, instr_i[5], instr_i[6]};
  assign off_half = {10'd0, instr_i[5], 1'b0};

  always_comb begin
    cand = '0;
    hit  = 1'b0;
    bad  = 1'b0;
    if (instr_i[1:0] == 2'b00) begin
      case (major)
        6'b100000: begin
          hit  = 1'b1;
          cand = {off_byte, reg_hi, 3'b100, reg_lo, OPC_LOAD};
        end
        6'b100001: begin
          hit  = 1'b1;
          cand = {off_half, reg_hi, (instr_i[6] ? 3'b001 : 3'b101), reg_lo, OPC_LOAD};
        end
        6'b100010: begin
          hit  = 1'b1;
          cand = {off_byte[11:5], reg_lo, reg_hi, 3'b000, off_byte[4:0], OPC_STORE};
        end
        6'b100011: begin
          hit  = 1'b1;
          bad  = instr_i[6];
          cand = {off_half[11:5], reg_lo, reg_hi, 3'b001, off_half[4:0], OPC_STORE};
        end
        default: ;
      endcase
    end else if (instr_i[1:0] == 2'b01 && major == 6'b100111) begin
      if (instr_i[6:5] == 2'b10) begin
        hit  = 1'b1;
        bad  = !mul_en_i;
        cand = {7'b0000001, reg_lo, reg_hi, 3'b000, reg_hi, OPC_OP};
      end else if (instr_i[6:5] == 2'b11) begin
        hit = 1'b1;
        case (instr_i[4:2])
          3'b000: cand = {12'h0FF, reg_hi, 3'b111, reg_hi, OPC_OPIMM};
          3'b001: begin
            bad  = !bitmanip_en_i;
            cand = {12'h604, reg_hi, 3'b001, reg_hi, OPC_OPIMM};
          end
          3'b010: begin
            bad  = !bitmanip_en_i;
            cand = {7'b0000100, 5'd0, reg_hi, 3'b100, reg_hi, OPC_OP};
          end
          3'b011: begin
            bad  = !bitmanip_en_i;
            cand = {12'h605, reg_hi, 3'b001, reg_hi, OPC_OPIMM};
          end
          3'b101: cand = {12'hFFF, reg_hi, 3'b100, reg_hi, OPC_OPIMM};
          default: bad = 1'b1;
        endcase
      end
    end
  end

  assign valid_o   = hit && !bad;
  assign illegal_o = hit && bad;
  assign instr_o   = valid_o ? cand : 32'd0;

  always_comb begin
    if (!$isunknown({instr_i, mul_en_i, bitmanip_en_i})) begin
      AST_FLAGS_EXCLUSIVE: assert (!(valid_o && illegal_o)) else $error("flags both set"); // R10
      AST_QUIET_WHEN_INVALID: assert (valid_o || instr_o == 32'd0) else $error("output not quiet"); // R9
      AST_REG_WINDOW: assert (!valid_o || (instr_o[19:18] == 2'b01 &&
                              (instr_o[6:0] == OPC_STORE || instr_o[11:10] == 2'b01)))
        else $error("register outside window"); // R8
      AST_MUL_GATED: assert (!(valid_o && instr_o[6:0] == OPC_OP && instr_o[31:25] == 7'b0000001)
                             || mul_en_i) else $error("multiply while disabled"); // R4
      AST_BITMANIP_GATED: assert (!(valid_o &&
                                  ((instr_o[6:0] == OPC_OPIMM && instr_o[14:12] == 3'b001) ||
                                   (instr_o[6:0] == OPC_OP && instr_o[31:25] == 7'b0000100)))
                                  || bitmanip_en_i) else $error("bit-manip while disabled"); // R5
    end
  end
endmodule

// File: tb/cmp16_expand_tb.sv
module cmp16_expand_tb;
  logic        clk = 1'b0;
  logic [15:0] instr;
  logic        mul_en, bm_en;
  logic [31:0] instr_o;
  logic        valid_o, illegal_o;
  int          n_cmp = 0, n_bad = 0;
  logic [33:0] exp_q[$];
  string       tag_q[$];
  logic        done = 1'b0;

  localparam logic [6:0] LOAD = 7'b0000011, OPIMM = 7'b0010011, OP = 7'b0110011;

  always #5 clk = ~clk;

  cmp16_expand u_dut (.instr_i(instr), .mul_en_i(mul_en), .bitmanip_en_i(bm_en),
                      .instr_o(instr_o), .valid_o(valid_o), .illegal_o(illegal_o));

  function automatic logic [31:0] enc_i(int imm, int rs1, int f3, int rd, logic [6:0] op);
    logic [11:0] im = imm[11:0];
    return {im, rs1[4:0], f3[2:0], rd[4:0], op};
  endfunction
  function automatic logic [31:0] enc_r(int f7, int rs2, int rs1, int f3, int rd, logic [6:0] op);
    return {f7[6:0], rs2[4:0], rs1[4:0], f3[2:0], rd[4:0], op};
  endfunction
  function automatic logic [31:0] enc_s(int imm, int rs2, int rs1, int f3);
    logic [11:0] im = imm[11:0];
    return {im[11:5], rs2[4:0], rs1[4:0], f3[2:0], im[4:0], 7'b0100011};
  endfunction

  task automatic drive(logic [15:0] w, logic me, logic be, logic [31:0] ei, logic ev, logic eil, string tag);
    @(posedge clk);
    instr  = w;
    mul_en = me;
    bm_en  = be;
    exp_q.push_back({ei, ev, eil});
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [33:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if ({instr_o, valid_o, illegal_o} !== e) begin
        n_bad++;
        $display("FAIL %s in=%h actual instr=%h v=%b il=%b expected instr=%h v=%b il=%b",
                 t, instr, instr_o, valid_o, illegal_o, e[33:2], e[1], e[0]);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    instr = 16'h0000; mul_en = 1'b0; bm_en = 1'b0;
    drive(16'h0000, 1'b1, 1'b1, 32'd0, 1'b0, 1'b0, "R9 idle word");
    for (int rs = 0; rs < 8; rs++)
      for (int rd = 0; rd < 8; rd++) begin
        for (int off = 0; off < 4; off++) begin
          drive({6'b100000, rs[2:0], off[0], off[1], rd[2:0], 2'b00}, 1'b0, 1'b0,
                enc_i(off, 8 + rs, 4, 8 + rd, LOAD), 1'b1, 1'b0, "R1 R8 byte load");
          drive({6'b100010, rs[2:0], off[0], off[1], rd[2:0], 2'b00}, 1'b1, 1'b0,
                enc_s(off, 8 + rd, 8 + rs, 0), 1'b1, 1'b0, "R3 byte store");
        end
        for (int o = 0; o < 2; o++) begin
          for (int s = 0; s < 2; s++)
            drive({6'b100001, rs[2:0], s[0], o[0], rd[2:0], 2'b00}, 1'b0, 1'b1,
                  enc_i(o * 2, 8 + rs, (s == 1) ? 1 : 5, 8 + rd, LOAD), 1'b1, 1'b0, "R2 half load");
          drive({6'b100011, rs[2:0], 1'b0, o[0], rd[2:0], 2'b00}, 1'b0, 1'b0,
                enc_s(o * 2, 8 + rd, 8 + rs, 1), 1'b1, 1'b0, "R3 half store");
          drive({6'b100011, rs[2:0], 1'b1, o[0], rd[2:0], 2'b00}, 1'b1, 1'b1,
                32'd0, 1'b0, 1'b1, "R3 reserved half store");
        end
        for (int me = 0; me < 2; me++)
          drive({6'b100111, rs[2:0], 2'b10, rd[2:0], 2'b01}, me[0], 1'b1,
                (me == 1) ? enc_r(1, 8 + rd, 8 + rs, 0, 8 + rs, OP) : 32'd0,
                me[0], !me[0], "R4 multiply");
      end
    for (int a = 0; a < 8; a++)
      for (int sel = 0; sel < 8; sel++)
        for (int be = 0; be < 2; be++) begin
          logic [31:0] ei;
          logic ev, eil;
          string t;
          ei = 32'd0; ev = 1'b0; eil = 1'b1; t = "R7 reserved unary";
          case (sel)
            0: begin ei = enc_i(12'h0FF, 8 + a, 7, 8 + a, OPIMM); ev = 1; eil = 0; t = "R6 zext byte"; end
            5: begin ei = enc_i(12'hFFF, 8 + a, 4, 8 + a, OPIMM); ev = 1; eil = 0; t = "R6 invert"; end
            1: begin ei = enc_i(12'h604, 8 + a, 1, 8 + a, OPIMM); t = "R5 sext byte"; end
            2: begin ei = enc_r(4, 0, 8 + a, 4, 8 + a, OP); t = "R5 zext half"; end
            3: begin ei = enc_i(12'h605, 8 + a, 1, 8 + a, OPIMM); t = "R5 sext half"; end
            default: ;
          endcase
          if (sel >= 1 && sel <= 3) begin
            ev = be[0]; eil = !be[0];
            if (be == 0) ei = 32'd0;
          end
          drive({6'b100111, a[2:0], 2'b11, sel[2:0], 2'b01}, !be[0], be[0], ei, ev, eil, t);
        end
    drive(16'h0001, 1'b1, 1'b1, 32'd0, 1'b0, 1'b0, "R9 other quadrant-1 op");
    drive(16'b100000_000_00_000_10, 1'b1, 1'b1, 32'd0, 1'b0, 1'b0, "R9 quadrant 2");
    drive(16'b100000_000_00_000_11, 1'b1, 1'b1, 32'd0, 1'b0, 1'b0, "R9 full-length low bits");
    drive(16'b100111_001_00_010_01, 1'b1, 1'b1, 32'd0, 1'b0, 1'b0, "R9 sub-group 00");
    drive(16'b100111_001_01_010_01, 1'b1, 1'b1, 32'd0, 1'b0, 1'b0, "R9 sub-group 01");
    drive(16'b100100_001_11_010_00, 1'b1, 1'b1, 32'd0, 1'b0, 1'b0, "R9 unused major quadrant 0");
    drive(16'b100011_111_11_111_01, 1'b1, 1'b1, 32'd0, 1'b0, 1'b0, "R9 R10 quadrant-1 arith");
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule